// File: doc/BRIEF.md
# Selectable 12/24-Hour BCD Timekeeper

This block keeps the time of day as three two-digit BCD fields: seconds, minutes and hours. It runs from a single clock. A one-cycle `tick` enable arrives once per second, and each tick moves the count forward by one second. Seconds roll into minutes and minutes roll into hours. The hour field runs through a span chosen by a mode input. The short span is 01 to 12 and the long span is 01 to 24.

A calendar downstream needs to know when a full day has passed. For that it receives the one-cycle `day_adv` pulse. In the long span every hour roll-over is a full day. In the short span a one-bit halving stage lets through only every second roll-over. Software or a front panel can write a new time through a load strobe. The block accepts the strobe only when all three fields hold legal values.

Top module: `bcd_timekeeper`

## Requirements
- R1: On each tick the seconds field counts up in BCD (ones in bits 3:0, tens in bits 7:4). After 59 it returns to 00.
- R2: The minutes field steps by one only on a tick that takes seconds from 59 to 00. It counts 00 to 59 and then returns to 00.
- R3: The hours field steps on a tick that takes minutes from 59 to 00. With `mode_24`=0 it runs 01 to 12 and then returns to 01. With `mode_24`=1 it runs 01 to 24 and then returns to 01.
- R4: With `mode_24`=1, every hour roll-over (24 to 01) raises `day_adv` for exactly one cycle. The pulse appears in the same cycle in which the hours output shows 01.
- R5: With `mode_24`=0, a halving stage passes only every second roll-over (12 to 01) to `day_adv`. The first roll-over after reset produces no pulse and the second one does.
- R6: When neither `tick` nor `load` is high, no output changes.
- R7: Synchronous active-low reset sets seconds to 00, minutes to 00, hours to 01 and `day_adv` to 0, and clears the halving stage.
- R8: A tick that finds the hours value above the limit of the present mode sets hours to 01. This happens whether or not minutes wrap, and no `day_adv` pulse is produced.
- R9: A `load` with legal values writes all three fields at the next edge. Legal values are seconds and minutes 00 to 59 and hours 01 to 24, with every digit 0 to 9. The load takes priority over a tick in the same cycle.
- R10: A `load` in which any field is illegal is ignored, and every output keeps its value unless a tick advances it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle once-per-second advance enable |
| mode_24 | input | 1 | 1 = hours 01..24, 0 = hours 01..12 |
| load | input | 1 | Preset strobe |
| load_sec | input | 8 | BCD seconds to preset |
| load_min | input | 8 | BCD minutes to preset |
| load_hr | input | 8 | BCD hours to preset |
| sec_o | output | 8 | BCD seconds |
| min_o | output | 8 | BCD minutes |
| hr_o | output | 8 | BCD hours |
| day_adv | output | 1 | One-cycle pulse per elapsed day |

## Verification
The bench builds the block with its default hour limits, 12 and 24. A full day at one tick per cycle would take 86,400 cycles. To avoid that, the stimulus often presets the time near 12:59:5x, 23:59:5x or 24:59:5x. This brings hour roll-overs, both halving-stage phases and the mode clamp within a few thousand cycles. Random loads include illegal digit codes and out-of-range fields, so rejection is tested as well. Mode flips land on hours 13 to 24, which exercises the clamp.

// File: rtl/tk_pkg.sv
// Shared constants and BCD helpers for the timekeeper.
// Assumes every field is two packed BCD digits: tens in [7:4], ones in [3:0].
package tk_pkg;
    localparam int unsigned DIGIT_W = 4;
    localparam int unsigned FIELD_W = 2 * DIGIT_W;
    localparam logic [FIELD_W-1:0] FIELD_ZERO = '0;
    localparam logic [FIELD_W-1:0] HOUR_FIRST = 8'h01;
    localparam logic [FIELD_W-1:0] MINSEC_LAST = 8'h59;

    typedef logic [FIELD_W-1:0] bcd_field_t;

    // Both digits are 0..9 and the whole value lies within [lo, hi].
    function automatic logic bcd_in_range(bcd_field_t v, bcd_field_t lo, bcd_field_t hi);
        return (v[DIGIT_W-1:0] <= 4'd9) && (v[FIELD_W-1:DIGIT_W] <= 4'd9)
               && (v >= lo) && (v <= hi);
    endfunction

    // Adds one to a valid two-digit BCD value.
    function automatic bcd_field_t bcd_inc(bcd_field_t v);
        bcd_field_t r;
        if (v[DIGIT_W-1:0] == 4'd9) begin
            r[DIGIT_W-1:0]       = '0;
            r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W] + 4'd1;
        end else begin
            r[DIGIT_W-1:0]       = v[DIGIT_W-1:0] + 4'd1;
            r[FIELD_W-1:DIGIT_W] = v[FIELD_W-1:DIGIT_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/tk_wrap_counter.sv
// Two-digit BCD counter from 00 up to LAST, then back to 00.
// Assumes load_en carries only values already checked as legal.
// wrap_o is combinational: high when adv_i would take LAST to 00.
module tk_wrap_counter
    import tk_pkg::*;
#(
    parameter bcd_field_t LAST = MINSEC_LAST
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv_i,
    input  logic       load_en_i,
    input  bcd_field_t load_val_i,
    output bcd_field_t value_o,
    output logic       wrap_o
);
    bcd_field_t cnt_q;

    // Detect the roll-over that carries into the next field.
    always_comb wrap_o = adv_i && !load_en_i && (cnt_q == LAST);

    // Count register: a load wins, then an advance.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= FIELD_ZERO;
        else if (load_en_i)      cnt_q <= load_val_i;
        else if (adv_i)          cnt_q <= (cnt_q == LAST) ? FIELD_ZERO : bcd_inc(cnt_q);
    end

    assign value_o = cnt_q;

    assert_digits_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[3:0] <= 4'd9) && (cnt_q <= LAST));
    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_en_i && cnt_q == LAST) |=> (cnt_q == FIELD_ZERO));
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tk_hour_counter.sv
// BCD hour counter whose span is 01..SHORT_LAST or 01..LONG_LAST, selected by long_i.
// Assumes adv_i is only high together with tick_i.
// A tick that finds the hour above the active limit sets it to 01 and reports no roll-over.
module tk_hour_counter
    import tk_pkg::*;
#(
    parameter bcd_field_t SHORT_LAST = 8'h12,
    parameter bcd_field_t LONG_LAST  = 8'h24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       adv_i,
    input  logic       long_i,
    input  logic       load_en_i,
    input  bcd_field_t load_val_i,
    output bcd_field_t value_o,
    output logic       cycle_wrap_o
);
    bcd_field_t hr_q;
    bcd_field_t limit;
    logic       over_limit;

    // Pick the active limit and flag values beyond it.
    always_comb begin
        limit        = long_i ? LONG_LAST : SHORT_LAST;
        over_limit   = (hr_q > limit);
        cycle_wrap_o = tick_i && adv_i && !load_en_i && !over_limit && (hr_q == limit);
    end

    // Hour register: load, then clamp, then normal advance.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hr_q <= HOUR_FIRST;
        else if (load_en_i)             hr_q <= load_val_i;
        else if (tick_i && over_limit)  hr_q <= HOUR_FIRST;
        else if (adv_i)                 hr_q <= (hr_q == limit) ? HOUR_FIRST : bcd_inc(hr_q);
    end

    assign value_o = hr_q;

    assert_hour_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_q != FIELD_ZERO) && (hr_q <= LONG_LAST));
    assert_clamp_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_en_i && over_limit) |=> (hr_q == HOUR_FIRST));
    assert_clamp_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        over_limit |-> !cycle_wrap_o);
endmodule

// File: rtl/tk_day_halver.sv
// Turns hour roll-overs into a registered one-cycle day pulse.
// In the long span every roll-over passes. In the short span a one-bit stage
// passes every second one, so each pulse marks 24 elapsed hours.
module tk_day_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic long_i,
    output logic day_o
);
    logic half_q;

    // Halving stage and pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            day_o  <= 1'b0;
        end else if (wrap_i) begin
            half_q <= long_i ? 1'b0 : !half_q;
            day_o  <= long_i | half_q;
        end else begin
            day_o  <= 1'b0;
        end
    end

    assert_single_cycle_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        day_o |=> !day_o);
    assert_short_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !long_i && !half_q) |=> (!day_o && half_q));
    assert_long_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && long_i) |=> day_o);
endmodule

// File: rtl/bcd_timekeeper.sv
// Top level: seconds -> minutes -> hours chain plus the day pulse stage.
// Assumes tick is a one-cycle enable. A load is taken only when every field is legal.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter logic [7:0] HOUR_SHORT_LAST = 8'h12,
    parameter logic [7:0] HOUR_LONG_LAST  = 8'h24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mode_24,
    input  logic       load,
    input  logic [7:0] load_sec,
    input  logic [7:0] load_min,
    input  logic [7:0] load_hr,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic       day_adv
);
    logic load_ok;
    logic adv_tick;
    logic sec_wrap;
    logic min_wrap;
    logic hr_wrap;

    // Check the preset fields and block the tick when a load is taken.
    always_comb begin
        load_ok  = load && bcd_in_range(load_sec, FIELD_ZERO, MINSEC_LAST)
                        && bcd_in_range(load_min, FIELD_ZERO, MINSEC_LAST)
                        && bcd_in_range(load_hr, HOUR_FIRST, HOUR_LONG_LAST);
        adv_tick = tick && !load_ok;
    end

    tk_wrap_counter #(.LAST(MINSEC_LAST)) sec_i (
        .clk(clk), .rst_n(rst_n), .adv_i(adv_tick), .load_en_i(load_ok),
        .load_val_i(load_sec), .value_o(sec_o), .wrap_o(sec_wrap)
    );

    tk_wrap_counter #(.LAST(MINSEC_LAST)) min_i (
        .clk(clk), .rst_n(rst_n), .adv_i(sec_wrap), .load_en_i(load_ok),
        .load_val_i(load_min), .value_o(min_o), .wrap_o(min_wrap)
    );

    tk_hour_counter #(.SHORT_LAST(HOUR_SHORT_LAST), .LONG_LAST(HOUR_LONG_LAST)) hr_i (
        .clk(clk), .rst_n(rst_n), .tick_i(adv_tick), .adv_i(min_wrap), .long_i(mode_24),
        .load_en_i(load_ok), .load_val_i(load_hr), .value_o(hr_o), .cycle_wrap_o(hr_wrap)
    );

    tk_day_halver day_i (
        .clk(clk), .rst_n(rst_n), .wrap_i(hr_wrap), .long_i(mode_24), .day_o(day_adv)
    );

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o) && !day_adv));
    assert_bad_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !load_ok && !tick) |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o)));
    assert_load_applied_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> (sec_o == $past(load_sec) && min_o == $past(load_min) && hr_o == $past(load_hr)));
    assert_minute_needs_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && sec_o != 8'h59) |=> $stable(min_o));
endmodule

// File: tb/bcd_timekeeper_tb_top.sv
module bcd_timekeeper_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode_24 = 1'b1;
    logic       load = 1'b0;
    logic [7:0] load_sec = '0;
    logic [7:0] load_min = '0;
    logic [7:0] load_hr = '0;
    logic [7:0] sec_o, min_o, hr_o;
    logic       day_adv;

    int checks = 0;
    int fails = 0;
    int e_sec, e_min, e_hr, e_day, e_half;

    always #4 clk = ~clk;

    bcd_timekeeper dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_24(mode_24), .load(load),
        .load_sec(load_sec), .load_min(load_min), .load_hr(load_hr),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .day_adv(day_adv)
    );

    function automatic logic [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return (b[7:4] > 4'd9 || b[3:0] > 4'd9) ? -1 : int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic legal_load(logic [7:0] s, logic [7:0] m, logic [7:0] h);
        int ds = from_bcd(s);
        int dm = from_bcd(m);
        int dh = from_bcd(h);
        return ds >= 0 && ds <= 59 && dm >= 0 && dm <= 59 && dh >= 1 && dh <= 24;
    endfunction

    // Reference model, advanced once per clock edge from the driven inputs.
    task automatic model_step();
        int lim = mode_24 ? 24 : 12;
        e_day = 0;
        if (load && legal_load(load_sec, load_min, load_hr)) begin
            e_sec = from_bcd(load_sec);
            e_min = from_bcd(load_min);
            e_hr  = from_bcd(load_hr);
        end else if (tick) begin
            logic cs = (e_sec == 59);
            logic cm = cs && (e_min == 59);
            e_sec = cs ? 0 : e_sec + 1;
            if (cs) e_min = (e_min == 59) ? 0 : e_min + 1;
            if (e_hr > lim) e_hr = 1;
            else if (cm) begin
                if (e_hr == lim) begin
                    e_hr = 1;
                    if (mode_24) begin e_day = 1; e_half = 0; end
                    else begin e_day = e_half; e_half = 1 - e_half; end
                end else e_hr = e_hr + 1;
            end
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag == "" ? "R1" : tag, "seconds", sec_o, to_bcd(e_sec));
        chk(tag == "" ? "R2" : tag, "minutes", min_o, to_bcd(e_min));
        chk(tag == "" ? "R3" : tag, "hours", hr_o, to_bcd(e_hr));
        chk(tag == "" ? (mode_24 ? "R4" : "R5") : tag, "day_adv", day_adv, e_day);
    endtask

    // Drive at a falling edge, pass one rising edge, compare at the next falling edge.
    task automatic cycle(logic t, logic m24, logic ld, logic [7:0] s, logic [7:0] mi,
                         logic [7:0] h, string tag);
        tick = t; mode_24 = m24; load = ld; load_sec = s; load_min = mi; load_hr = h;
        model_step();
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_sec = 0; e_min = 0; e_hr = 1; e_day = 0; e_half = 0;
        compare_all("R7");

        // R9 + R4: the long span crosses 24 -> 01 with a pulse.
        cycle(0, 1, 1, 8'h59, 8'h59, 8'h23, "R9");
        cycle(1, 1, 0, 0, 0, 0, "R3");
        cycle(0, 1, 1, 8'h59, 8'h59, 8'h24, "R9");
        cycle(1, 1, 0, 0, 0, 0, "R4");
        cycle(0, 1, 0, 0, 0, 0, "R4");
        // R5: the short span pulses only on the second roll-over.
        cycle(0, 0, 1, 8'h59, 8'h59, 8'h12, "R9");
        cycle(1, 0, 0, 0, 0, 0, "R5");
        cycle(0, 0, 1, 8'h59, 8'h59, 8'h12, "R9");
        cycle(1, 0, 0, 0, 0, 0, "R5");
        // R10: an illegal digit and an hour of 00 are both rejected.
        cycle(0, 0, 1, 8'h5A, 8'h10, 8'h05, "R10");
        cycle(0, 0, 1, 8'h10, 8'h10, 8'h00, "R10");
        cycle(1, 0, 1, 8'h60, 8'h10, 8'h05, "R10");
        // R8: switching to the short span clamps hour 18 on the next tick.
        cycle(0, 1, 1, 8'h00, 8'h30, 8'h18, "R9");
        cycle(0, 0, 0, 0, 0, 0, "R6");
        cycle(1, 0, 0, 0, 0, 0, "R8");
        // R9: a load beats a simultaneous tick.
        cycle(1, 1, 1, 8'h42, 8'h17, 8'h09, "R9");
        // R6: idle cycles hold.
        repeat (3) cycle(0, 1, 0, 0, 0, 0, "R6");
        // R1 / R2: a plain run across a minute boundary.
        cycle(0, 1, 1, 8'h57, 8'h08, 8'h03, "R9");
        repeat (5) cycle(1, 1, 0, 0, 0, 0, "");

        for (int n = 0; n < 20000; n++) begin
            int r = $urandom_range(0, 99);
            logic m = mode_24;
            if ($urandom_range(0, 199) == 0) m = !m;
            if (r < 6) begin
                logic [7:0] s = ($urandom_range(0, 7) == 0) ? 8'($urandom) : to_bcd($urandom_range(55, 59));
                logic [7:0] mi = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h59;
                logic [7:0] h;
                case ($urandom_range(0, 3))
                    0: h = 8'h12;
                    1: h = 8'h24;
                    2: h = to_bcd($urandom_range(1, 24));
                    default: h = 8'($urandom);
                endcase
                cycle($urandom_range(0, 1), m, 1, s, mi, h,
                      legal_load(s, mi, h) ? "R9" : "R10");
            end else if (r < 25) begin
                cycle(0, m, 0, 0, 0, 0, "R6");
            end else begin
                cycle(1, m, 0, 0, 0, 0, (e_hr > (m ? 24 : 12)) ? "R8" : "");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule